// File: doc/BRIEF.md
# Timer Output Compare Unit

An 8-bit timer/counter with a single output compare channel. The counter moves one step on each cycle where the timer tick enable is high. An equality comparator checks the counter against an active compare register. A match raises a sticky interrupt flag and drives a waveform output. The 2-bit waveform mode picks one of four counting schemes: a plain wrapping count, a count that clears on match, fast PWM and phase-correct PWM.

Software reaches the block through write strobes that share one data bus: one for the counter, one for the compare value and one for the mode fields. A force strobe fires a compare action by hand. A write-one strobe clears the flag. In the two PWM modes the compare value is double buffered: a write lands in a shadow register and moves to the active register only at the top of the count. In the two non-PWM modes a write goes straight to the active register.

A counter write masks the compare of the next tick. The mask holds even while no ticks arrive. Loading the counter with the compare value therefore leaves out that match.

Top module: `tmr_cmp8`

## Requirements
- R1: After reset the counter is 0 and the waveform output and flag are 0. The mode is 00 (plain count) and the output mode is 00.
- R2: The counter changes only on a tick or a counter write. In mode 00 (plain) and mode 11 (fast PWM) a tick adds one, and 255 wraps to 0.
- R3: In mode 10 (clear on match) a tick that produces an unmasked match loads the counter with 0 instead of adding one.
- R4: In mode 01 (phase-correct PWM) the counter counts up to 255 and turns there (255 is followed by 254). It counts down to 0 and turns there (0 is followed by 1).
- R5: A tick that is not masked and finds the counter equal to the active compare value sets the flag, visible the cycle after. A clear strobe (flag_clr=1) drops the flag. A match in the same cycle as a clear leaves the flag set.
- R6: A counter write masks the compare of the first tick after it, however many tickless cycles lie between. A tick in the same cycle as the write is masked too. A masked match sets no flag, changes no output and clears no counter.
- R7: In modes 00 and 10 a match applies the output mode to the output: 01 toggles it, 10 clears it, 11 sets it. Output mode 00 holds the output at 0 in every mode.
- R8: In modes 00 and 10 a force strobe applies the output-mode action exactly as a match does. It leaves the flag and the counter unchanged. In modes 01 and 11 a force strobe has no effect.
- R9: In modes 00 and 10 a compare write takes effect at once: the tick after the write already compares against the new value.
- R10: In modes 01 and 11 a compare write lands in a shadow register. The active value loads from the shadow on a tick that finds the counter at 255 (in mode 01 only while counting up). Until then matches use the old value.
- R11: In mode 11 with output mode 10 a match clears the output, and the wrap from 255 to 0 sets it. When both happen on the same tick, the set wins. Output mode 11 inverts both actions. Output mode 01 holds the output at 0.
- R12: In mode 01 with output mode 10 a match while counting up clears the output, and a match while counting down sets it. Output mode 11 inverts both actions. Output mode 01 holds the output at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer tick enable; the counter moves one step per cycle where it is high |
| wr_cnt | input | 1 | Counter write strobe |
| wr_ocr | input | 1 | Compare value write strobe |
| wr_ctl | input | 1 | Mode field write strobe |
| wdata | input | 8 | Write data for the counter and compare value |
| ctl_wgm | input | 2 | Waveform mode, loaded on wr_ctl |
| ctl_com | input | 2 | Output mode, loaded on wr_ctl |
| force_cmp | input | 1 | Force compare strobe |
| flag_clr | input | 1 | Write-one clear of the compare flag |
| wave_o | output | 1 | Waveform output |
| flag_o | output | 1 | Compare interrupt flag |
| cnt_o | output | 8 | Current counter value |

## Verification
Every result is a register, so the effect of a strobe or tick sampled at one rising edge shows on cnt_o, wave_o and flag_o one cycle later. The exception is a masked compare: its result is the absence of a flag and of an output change on the tick after the write, which may come many cycles later. A shadowed compare value shows only after the next pass through 255. The bench drives its inputs at the falling edge and advances its own model at the rising edge. It compares all three outputs at the following falling edge, so every check lands in the cycle where its result is due. Directed sequences count the ticks to each corner by hand: masked write-equal, clear against match, force, the wrap load and the phase-correct turn.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  parameter int unsigned CNT_W = 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_PCPWM = 2'b01,
    MODE_CTC   = 2'b10,
    MODE_FAST  = 2'b11
  } tmode_e;

  typedef enum logic [1:0] {
    OUT_OFF = 2'b00,
    OUT_TGL = 2'b01,
    OUT_CLR = 2'b10,
    OUT_SET = 2'b11
  } omode_e;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             up;
  } cstep_t;

  function automatic logic is_pwm(input tmode_e m);
    return (m == MODE_PCPWM) || (m == MODE_FAST);
  endfunction

  // Next counter position and direction for one tick.
  function automatic cstep_t count_next(input logic [CNT_W-1:0] c,
                                        input logic up,
                                        input tmode_e m,
                                        input logic clr);
    cstep_t r;
    r.up  = 1'b1;
    r.cnt = c + 1'b1;
    case (m)
      MODE_CTC: begin
        if (clr) r.cnt = CNT_ZERO;
      end
      MODE_PCPWM: begin
        if (up) begin
          if (c == CNT_MAX) begin
            r.cnt = c - 1'b1;
            r.up  = 1'b0;
          end
        end else if (c == CNT_ZERO) begin
          r.cnt = c + 1'b1;
        end else begin
          r.cnt = c - 1'b1;
          r.up  = 1'b0;
        end
      end
      default: ;
    endcase
    return r;
  endfunction

  // Output action of a non-PWM event.
  function automatic logic act_apply(input omode_e o, input logic cur);
    case (o)
      OUT_TGL: return ~cur;
      OUT_CLR: return 1'b0;
      OUT_SET: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Next waveform output level.
  function automatic logic wave_next(input tmode_e m, input omode_e o,
                                     input logic cur, input logic hit,
                                     input logic frc, input logic bot,
                                     input logic up);
    logic v;
    v = cur;
    if (o == OUT_OFF) begin
      v = 1'b0;
    end else if (!is_pwm(m)) begin
      if (hit || frc) v = act_apply(o, cur);
    end else if (o == OUT_TGL) begin
      v = 1'b0;
    end else if (m == MODE_FAST) begin
      if (hit) v = o[0];
      if (bot) v = ~o[0];
    end else if (hit) begin
      v = up ? o[0] : ~o[0];
    end
    return v;
  endfunction

endpackage

// File: rtl/tcmp_counter.sv
module tcmp_counter
  import tcmp_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_cnt,
  input  logic [W-1:0] wdata,
  input  tmode_e       mode,
  input  logic         ctc_clr,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         blk
);

  cstep_t nxt;

  always_comb begin
    nxt = count_next(cnt, up, mode, ctc_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
      blk <= 1'b0;
    end else if (wr_cnt) begin
      cnt <= wdata;
      blk <= 1'b1;
    end else if (tick) begin
      cnt <= nxt.cnt;
      up  <= nxt.up;
      blk <= 1'b0;
    end
  end

endmodule

// File: rtl/tcmp_ocr.sv
module tcmp_ocr #(
  parameter int unsigned W = tcmp_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ocr,
  input  logic [W-1:0] wdata,
  input  logic         pwm,
  input  logic         load,
  output logic [W-1:0] act
);

  logic [W-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      act    <= '0;
    end else begin
      if (wr_ocr) shadow <= wdata;
      if (wr_ocr && !pwm) act <= wdata;
      else if (load)      act <= shadow;
    end
  end

endmodule

// File: rtl/tcmp_wave.sv
module tcmp_wave
  import tcmp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  tmode_e mode,
  input  omode_e omode,
  input  logic   match_ev,
  input  logic   force_ev,
  input  logic   bottom_ev,
  input  logic   up,
  input  logic   flag_clr,
  output logic   wave,
  output logic   flag
);

  logic wave_d;

  always_comb begin
    wave_d = wave_next(mode, omode, wave, match_ev, force_ev, bottom_ev, up);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave <= 1'b0;
      flag <= 1'b0;
    end else begin
      wave <= wave_d;
      flag <= match_ev | (flag & ~flag_clr);
    end
  end

endmodule

// File: rtl/tmr_cmp8.sv
module tmr_cmp8
  import tcmp_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_cnt,
  input  logic          wr_ocr,
  input  logic          wr_ctl,
  input  logic [CW-1:0] wdata,
  input  logic [1:0]    ctl_wgm,
  input  logic [1:0]    ctl_com,
  input  logic          force_cmp,
  input  logic          flag_clr,
  output logic          wave_o,
  output logic          flag_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] TOP = '1;

  tmode_e        mode;
  omode_e        omode;
  logic [CW-1:0] cnt;
  logic [CW-1:0] act;
  logic          up;
  logic          blk;
  logic          pwm;
  logic          adv;
  logic          at_top;
  logic          match_ev;
  logic          bottom_ev;
  logic          load_ev;
  logic          force_ev;
  logic          ctc_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= MODE_PLAIN;
      omode <= OUT_OFF;
    end else if (wr_ctl) begin
      mode  <= tmode_e'(ctl_wgm);
      omode <= omode_e'(ctl_com);
    end
  end

  // named internal events
  assign pwm       = is_pwm(mode);
  assign adv       = tick & ~wr_cnt;
  assign at_top    = (cnt == TOP);
  assign match_ev  = adv & ~blk & (cnt == act);
  assign bottom_ev = adv & at_top & (mode == MODE_FAST);
  assign load_ev   = adv & at_top & pwm & ((mode == MODE_FAST) | up);
  assign force_ev  = force_cmp & ~pwm;
  assign ctc_clr   = match_ev & (mode == MODE_CTC);

  tcmp_counter #(.W(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_cnt  (wr_cnt),
    .wdata   (wdata),
    .mode    (mode),
    .ctc_clr (ctc_clr),
    .cnt     (cnt),
    .up      (up),
    .blk     (blk)
  );

  tcmp_ocr #(.W(CW)) u_ocr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ocr (wr_ocr),
    .wdata  (wdata),
    .pwm    (pwm),
    .load   (load_ev),
    .act    (act)
  );

  tcmp_wave u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .omode     (omode),
    .match_ev  (match_ev),
    .force_ev  (force_ev),
    .bottom_ev (bottom_ev),
    .up        (up),
    .flag_clr  (flag_clr),
    .wave      (wave_o),
    .flag      (flag_o)
  );

  assign cnt_o = cnt;

endmodule

// File: rtl/tcmp_chk.sv
module tcmp_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_cnt,
  input logic [1:0]    mode,
  input logic          pwm,
  input logic          blk,
  input logic          up,
  input logic          match_ev,
  input logic          load_ev,
  input logic          flag,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] act
);

  localparam logic [CW-1:0] TOP  = '1;
  localparam logic [CW-1:0] TOP1 = TOP - 1'b1;
  localparam logic [CW-1:0] ONE  = 1;

  // R6
  blk_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && tick) |-> !match_ev);

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> flag);

  // R8
  flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !match_ev) |=> !flag);

  // R3
  ctc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && match_ev) |=> (cnt == '0));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt));

  // R4
  pc_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && tick && !wr_cnt && cnt == TOP) |=> (cnt == TOP1));

  // R4
  pc_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && tick && !wr_cnt && cnt == '0 && !up) |=> (cnt == ONE));

  // R10
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !load_ev) |=> $stable(act));

endmodule

bind tmr_cmp8 tcmp_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .wr_cnt   (wr_cnt),
  .mode     (mode),
  .pwm      (pwm),
  .blk      (blk),
  .up       (up),
  .match_ev (match_ev),
  .load_ev  (load_ev),
  .flag     (flag_o),
  .cnt      (cnt),
  .act      (act)
);

// File: tb/sim_tmr_cmp8.sv
module sim_tmr_cmp8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_cnt = 1'b0, wr_ocr = 1'b0, wr_ctl = 1'b0;
  logic [7:0] wdata = '0;
  logic [1:0] ctl_wgm = '0, ctl_com = '0;
  logic       force_cmp = 1'b0, flag_clr = 1'b0;
  logic       wave_o, flag_o;
  logic [7:0] cnt_o;

  int nvec = 0, nbad = 0;
  bit done = 0;

  // model state
  logic [7:0] m_cnt, m_act, m_buf;
  logic       m_up, m_blk, m_wave, m_flag;
  logic [1:0] m_wgm, m_com;

  always #10 clk = ~clk;

  tmr_cmp8 u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_cnt(wr_cnt), .wr_ocr(wr_ocr),
    .wr_ctl(wr_ctl), .wdata(wdata), .ctl_wgm(ctl_wgm), .ctl_com(ctl_com),
    .force_cmp(force_cmp), .flag_clr(flag_clr),
    .wave_o(wave_o), .flag_o(flag_o), .cnt_o(cnt_o)
  );

  task automatic model_reset();
    m_cnt = 0; m_act = 0; m_buf = 0; m_up = 1; m_blk = 0;
    m_wave = 0; m_flag = 0; m_wgm = 0; m_com = 0;
  endtask

  // one edge of the reference behaviour, written from the requirements
  task automatic model_edge();
    logic pw, go, top, hit, bot, ld, fv, nw;
    logic [7:0] nc, na;
    logic nu, nblk;
    pw  = (m_wgm == 2'b01) || (m_wgm == 2'b11);
    go  = tick && !wr_cnt;
    top = (m_cnt == 8'hFF);
    hit = go && !m_blk && (m_cnt == m_act);
    bot = go && top && (m_wgm == 2'b11);
    ld  = go && top && pw && (m_wgm == 2'b11 || m_up);
    fv  = force_cmp && !pw;
    nw  = m_wave;
    if (m_com == 2'b00) nw = 1'b0;
    else if (!pw) begin
      if (hit || fv) nw = (m_com == 2'b01) ? ~m_wave : m_com[0];
    end else if (m_com == 2'b01) nw = 1'b0;
    else if (m_wgm == 2'b11) begin
      if (hit) nw = m_com[0];
      if (bot) nw = ~m_com[0];
    end else if (hit) nw = m_up ? m_com[0] : ~m_com[0];
    nc = m_cnt; nu = m_up; nblk = m_blk;
    if (wr_cnt) begin
      nc = wdata; nblk = 1;
    end else if (tick) begin
      nblk = 0; nu = 1;
      if (m_wgm == 2'b10 && hit) nc = 0;
      else if (m_wgm == 2'b01) begin
        if (m_up && top) begin nc = 8'hFE; nu = 0; end
        else if (m_up) nc = m_cnt + 1;
        else if (m_cnt == 0) nc = 1;
        else begin nc = m_cnt - 1; nu = 0; end
      end else nc = m_cnt + 1;
    end
    na = m_act;
    if (wr_ocr && !pw) na = wdata;
    else if (ld) na = m_buf;
    if (wr_ocr) m_buf = wdata;
    m_flag = hit || (m_flag && !flag_clr);
    m_wave = nw; m_cnt = nc; m_up = nu; m_blk = nblk; m_act = na;
    if (wr_ctl) begin m_wgm = ctl_wgm; m_com = ctl_com; end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    nvec++;
    if (cnt_o !== m_cnt || wave_o !== m_wave || flag_o !== m_flag) begin
      nbad++;
      $display("FAIL %s: cnt/wave/flag got %0d/%0b/%0b expected %0d/%0b/%0b",
               tag, cnt_o, wave_o, flag_o, m_cnt, m_wave, m_flag);
    end
    tick = 0; wr_cnt = 0; wr_ocr = 0; wr_ctl = 0; force_cmp = 0; flag_clr = 0;
  endtask

  task automatic expect_v(input string tag, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic t_ctl(input logic [1:0] g, input logic [1:0] c, input string tag);
    wr_ctl = 1; ctl_wgm = g; ctl_com = c; step(tag);
  endtask
  task automatic t_ocr(input logic [7:0] v, input string tag);
    wr_ocr = 1; wdata = v; step(tag);
  endtask
  task automatic t_cnt(input logic [7:0] v, input string tag);
    wr_cnt = 1; wdata = v; step(tag);
  endtask
  task automatic t_tick(input int n, input string tag);
    for (int i = 0; i < n; i++) begin tick = 1; step(tag); end
  endtask

  function automatic string mode_tag(input logic [1:0] g);
    case (g)
      2'b00: return "R2";
      2'b01: return "R4";
      2'b10: return "R3";
      default: return "R11";
    endcase
  endfunction

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    void'($urandom(32'd2718));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    expect_v("R1 cnt", cnt_o, 0);
    expect_v("R1 wave", wave_o, 0);
    expect_v("R1 flag", flag_o, 0);

    // R9 / R7 / R5: plain mode, toggle, direct compare write
    t_ctl(2'b00, 2'b01, "R7");
    t_ocr(8'd5, "R9");
    t_cnt(8'd3, "R9");
    t_tick(3, "R9");
    expect_v("R9 flag", flag_o, 1);
    expect_v("R7 wave", wave_o, 1);
    expect_v("R2 cnt", cnt_o, 6);
    flag_clr = 1; tick = 1; step("R5");
    expect_v("R5 cleared", flag_o, 0);
    t_cnt(8'd4, "R5"); t_tick(2, "R5");
    t_cnt(8'd4, "R5"); t_tick(1, "R5");
    flag_clr = 1; tick = 1; step("R5");
    expect_v("R5 set wins", flag_o, 1);

    // R6: write equal to compare, stopped timer, then tick
    flag_clr = 1; step("R6");
    t_cnt(8'd5, "R6");
    for (int i = 0; i < 3; i++) step("R6");
    t_tick(1, "R6");
    expect_v("R6 flag", flag_o, 0);
    expect_v("R6 cnt", cnt_o, 6);
    // same-cycle write and tick
    wr_cnt = 1; tick = 1; wdata = 8'd5; step("R6");
    t_tick(1, "R6");
    expect_v("R6 same-cycle flag", flag_o, 0);

    // R8: force in non-PWM
    t_ctl(2'b00, 2'b10, "R8"); force_cmp = 1; step("R8");
    expect_v("R8 clear", wave_o, 0);
    t_ctl(2'b00, 2'b11, "R8"); force_cmp = 1; step("R8");
    expect_v("R8 set", wave_o, 1);
    expect_v("R8 flag", flag_o, 0);
    expect_v("R8 cnt", cnt_o, 6);

    // R3: clear-on-match
    t_ctl(2'b10, 2'b01, "R3");
    t_ocr(8'd4, "R3"); t_cnt(8'd2, "R3"); t_tick(3, "R3");
    expect_v("R3 cnt", cnt_o, 0);
    expect_v("R3 flag", flag_o, 1);

    // R10 / R11: fast PWM with shadowed compare
    flag_clr = 1; step("R10");
    t_ctl(2'b11, 2'b10, "R11");
    t_ocr(8'd100, "R10");
    t_cnt(8'd2, "R10"); t_tick(3, "R10");
    expect_v("R10 old value still active", flag_o, 1);
    flag_clr = 1; step("R10");
    t_cnt(8'd254, "R10"); t_tick(2, "R11");
    expect_v("R11 set at wrap", wave_o, 1);
    t_tick(100, "R10");
    expect_v("R10 no match at 4", flag_o, 0);
    expect_v("R10 cnt", cnt_o, 100);
    t_tick(1, "R11");
    expect_v("R10 new value matches", flag_o, 1);
    expect_v("R11 clear on match", wave_o, 0);
    // R8: force ignored in PWM
    t_ctl(2'b11, 2'b11, "R8"); force_cmp = 1; step("R8");
    expect_v("R8 PWM force ignored", wave_o, 0);

    // R4 / R12: phase-correct
    t_ctl(2'b01, 2'b10, "R12");
    t_ocr(8'd10, "R12");
    t_cnt(8'd254, "R4"); t_tick(2, "R4");
    expect_v("R4 turn", cnt_o, 254);
    t_tick(600, "R12");
    t_ctl(2'b01, 2'b11, "R12");
    t_tick(600, "R12");

    // constrained random per mode
    for (int m = 0; m < 4; m++) begin
      r = $urandom;
      t_ctl(2'(m), r[1:0], mode_tag(2'(m)));
      for (int k = 0; k < 4000; k++) begin
        r = $urandom;
        tick = (r[3:0] < 4'd11);
        if (r[9:4] == 6'd0) begin wr_cnt = 1; end
        if (r[15:10] == 6'd1) begin wr_ocr = 1; end
        wdata = (r[17:16] == 2'd0) ? 8'hFF : (r[17:16] == 2'd1) ? 8'h00 : 8'($urandom);
        force_cmp = (r[22:18] == 5'd2);
        flag_clr  = (r[25:23] == 3'd3);
        if (r[31:26] == 6'd4 && k[2]) begin
          wr_ctl = 1; ctl_wgm = 2'(m); ctl_com = r[27:26] ^ 2'(k);
        end
        step(m[1:0] == 2'b00 ? "R7" : mode_tag(2'(m)));
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule